// File: doc/BRIEF.md
# First-Order Dithered Switching Block

This block is the smallest cell of a mismatch-shaping encoder for a multi-element DAC. It takes a sample in the range 0 to 2 and splits it between two 1-bit unit-element drives. The two bits always add up to the sample. When the sample is even, the split is forced: both bits are 0 or both are 1. When the sample is odd, exactly one element turns on. Which one turns on is chosen by a steering value s of +1 or -1. That value comes from a first-order error-feedback loop with no signal input, so the steering sequence is first-order high-pass shaped. The result is that the error from mismatch between the two elements is pushed out of the signal band.

The loop state is a three-valued integrator. It is held in two flip-flops that take four encodings. Two of those encodings both mean zero. The flip-flops advance only on odd samples. When the integrator is nonzero, the steering follows its sign. When it is zero, the choice is free. With dither enabled, that free choice is taken from a free-running 16-bit LFSR, which breaks up idle tones. With dither disabled, the zero state always picks +1. The two outputs are the top bit of the sample plus a 0 or 1 correction, with the divide-by-two done by dropping the LSB.

Top module: `sb1_dither_switch`

## Requirements
- R1: When `din` is 0 or 2, `out_a` and `out_b` both equal `din`/2, and the integrator state is left unchanged for later samples.
- R2: For every legal input (0, 1, 2), `out_a + out_b` equals `din`.
- R3: On an odd sample with integrator +1 the steering is +1 (`out_a`=1, `out_b`=0). With integrator -1 it is -1 (`out_a`=0, `out_b`=1).
- R4: The integrator is zero after reset. On each odd sample it becomes its old value minus the steering value, so a nonzero state always returns to zero.
- R5: With `dith_en` low, a zero integrator steers +1. A run of odd samples therefore gives `out_a` = 1,0,1,0,... starting from reset.
- R6: With `dith_en` high, a zero integrator steers by LFSR bit 0: 1 gives +1 and 0 gives -1. Nonzero states are not affected by dither.
- R7: The LFSR is a 16-bit right-shifting Galois register with feedback mask 16'hB400, loaded with the seed (default 16'hACE1) in reset. It advances on every clock out of reset, whatever the value of `din`.
- R8: The running sum of the steering values (`out_a - out_b` on odd samples) since reset always stays within -1 to +1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 2 | Sample to split, 0 to 2 |
| dith_en | input | 1 | Use the random sign in the zero integrator state |
| out_a | output | 1 | First element drive, (din+s)/2 |
| out_b | output | 1 | Second element drive, (din-s)/2 |

## Verification
The hardest case to reach is a dithered decision. It needs the integrator to sit in a zero state on an odd sample while dither is on, and the expected result then depends on the LFSR bit in that exact clock. The bench keeps its own LFSR model that runs from reset release. It mixes even samples and dither toggles between odd ones, so the LFSR phase slides against the integrator phase and both signs of the random choice occur. A reset in mid-run checks that the integrator and the LFSR restart together.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
   localparam int unsigned SMP_W = 2;
   localparam int unsigned SUM_W = SMP_W + 1;

   // integrator encodings: equal flops carry a sign, unequal flops mean zero
   localparam logic [1:0] ST_NEG = 2'b00;
   localparam logic [1:0] ST_Z0  = 2'b01;
   localparam logic [1:0] ST_Z1  = 2'b10;
   localparam logic [1:0] ST_POS = 2'b11;

   function automatic logic is_zero_state(input logic [1:0] st);
      return st[1] ^ st[0];
   endfunction
endpackage

// File: rtl/sb_lfsr.sv
`timescale 1ns/1ps
module sb_lfsr #(
   parameter int unsigned       W    = 16,
   parameter logic [W-1:0]      MASK = 16'hB400,
   parameter logic [W-1:0]      SEED = 16'hACE1
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] state_o,
   output logic         rnd_o
);
   if (W < 3) begin : g_bad_w
      $error("sb_lfsr: width must be at least 3");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("sb_lfsr: seed must be nonzero");
   end
   if (MASK[W-1] == 1'b0) begin : g_bad_mask
      $error("sb_lfsr: mask must feed the top bit");
   end

   logic [W-1:0] reg_q;
   logic [W-1:0] reg_d;

   always_comb begin
      reg_d = reg_q >> 1;
      if (reg_q[0]) reg_d = reg_d ^ MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q <= SEED;
      else        reg_q <= reg_d;
   end

   assign state_o = reg_q;
   assign rnd_o   = reg_q[0];
endmodule

// File: rtl/sb_steer.sv
`timescale 1ns/1ps
module sb_steer #(
   parameter bit DITHER_IMPL = 1'b1
) (
   input  logic [1:0] st,
   input  logic       dith_en,
   input  logic       rnd,
   output logic       pos,
   output logic [1:0] st_nxt
);
   import sb_pkg::*;

   logic zero_st;
   logic zero_pick;

   assign zero_st = is_zero_state(st);

   if (DITHER_IMPL) begin : g_dither
      // random bit low inverts the default +1 choice
      assign zero_pick = ~(dith_en & ~rnd);
   end else begin : g_plain
      logic unused_in;
      assign unused_in = dith_en ^ rnd;
      assign zero_pick = 1'b1;
   end

   always_comb begin
      if (zero_st) begin
         pos    = zero_pick;
         st_nxt = zero_pick ? ST_NEG : ST_POS;
      end else begin
         pos    = st[0];
         st_nxt = st[0] ? ST_Z0 : ST_Z1;
      end
   end
endmodule

// File: rtl/sb_split.sv
`timescale 1ns/1ps
module sb_split (
   input  logic [sb_pkg::SMP_W-1:0] smp,
   input  logic                     pos,
   output logic                     half_a,
   output logic                     half_b
);
   import sb_pkg::*;

   logic [SUM_W-1:0] sum_a;
   logic [SUM_W-1:0] sum_b;

   assign sum_a = {1'b0, smp} + {{(SUM_W-1){1'b0}}, pos};
   assign sum_b = {1'b0, smp} + {{(SUM_W-1){1'b0}}, ~pos};

   // drop the LSB: (smp + bit) / 2, at most 1 for legal samples
   assign half_a = sum_a[1];
   assign half_b = sum_b[1];

   logic unused_bits;
   assign unused_bits = sum_a[0] ^ sum_a[2] ^ sum_b[0] ^ sum_b[2];
endmodule

// File: rtl/sb1_dither_switch.sv
`timescale 1ns/1ps
module sb1_dither_switch #(
   parameter int unsigned            LFSR_W      = 16,
   parameter logic [LFSR_W-1:0]      LFSR_MASK   = 16'hB400,
   parameter logic [LFSR_W-1:0]      LFSR_SEED   = 16'hACE1,
   parameter bit                     DITHER_IMPL = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] din,
   input  logic       dith_en,
   output logic       out_a,
   output logic       out_b
);
   import sb_pkg::*;

   logic [LFSR_W-1:0] lfsr_state;
   logic              rnd_bit;
   logic [1:0]        integ_q;
   logic [1:0]        integ_nxt;
   logic              steer_pos;

   sb_lfsr #(.W(LFSR_W), .MASK(LFSR_MASK), .SEED(LFSR_SEED)) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .state_o (lfsr_state),
      .rnd_o   (rnd_bit)
   );

   sb_steer #(.DITHER_IMPL(DITHER_IMPL)) u_steer (
      .st      (integ_q),
      .dith_en (dith_en),
      .rnd     (rnd_bit),
      .pos     (steer_pos),
      .st_nxt  (integ_nxt)
   );

   // input LSB acts as the clock enable of the integrator pair
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      integ_q <= ST_Z0;
      else if (din[0]) integ_q <= integ_nxt;
   end

   sb_split u_split (
      .smp    (din),
      .pos    (steer_pos),
      .half_a (out_a),
      .half_b (out_b)
   );
endmodule

// File: rtl/sb1_dither_switch_chk.sv
`timescale 1ns/1ps
module sb1_dither_switch_chk #(
   parameter int unsigned LFSR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        din,
   input logic              dith_en,
   input logic              out_a,
   input logic              out_b,
   input logic [1:0]        integ_q,
   input logic [LFSR_W-1:0] lfsr_state
);
   p_even_split_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!din[0]) |-> (out_a == out_b));

   p_even_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!din[0]) |=> $stable(integ_q));

   p_sum_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (din != 2'd3) |-> (({1'b0, out_a} + {1'b0, out_b}) == din));

   p_pos_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (din[0] && integ_q == 2'b11) |-> (out_a && !out_b));

   p_neg_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (din[0] && integ_q == 2'b00) |-> (!out_a && out_b));

   p_back_to_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (din[0] && (integ_q[1] == integ_q[0])) |=> (integ_q[1] != integ_q[0]));

   p_zero_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (din[0] && !dith_en && (integ_q[1] != integ_q[0])) |-> out_a);

   p_lfsr_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_state != '0);

   p_lfsr_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (lfsr_state != $past(lfsr_state)));
endmodule

bind sb1_dither_switch sb1_dither_switch_chk #(.LFSR_W(LFSR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .din        (din),
   .dith_en    (dith_en),
   .out_a      (out_a),
   .out_b      (out_b),
   .integ_q    (integ_q),
   .lfsr_state (lfsr_state)
);

// File: tb/sim_sb1_dither_switch.sv
`timescale 1ns/1ps
module sim_sb1_dither_switch;
   localparam time PER = 10;
   localparam logic [15:0] MASK = 16'hB400;
   localparam logic [15:0] SEED = 16'hACE1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] din = 2'd0;
   logic       dith_en = 1'b0;
   logic       out_a;
   logic       out_b;

   int n_checks = 0;
   int n_fail   = 0;
   int mv       = 0;
   int ssum     = 0;
   bit finished = 0;

   typedef struct {
      logic       a;
      logic       b;
      logic [1:0] d;
      string      tag;
   } exp_t;
   exp_t q_exp[$];

   always #(PER/2) clk = ~clk;

   sb1_dither_switch u0 (
      .clk(clk), .rst_n(rst_n), .din(din), .dith_en(dith_en),
      .out_a(out_a), .out_b(out_b)
   );

   // reference random source per R7
   logic [15:0] m_lfsr;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n)        m_lfsr <= SEED;
      else if (m_lfsr[0]) m_lfsr <= (m_lfsr >> 1) ^ MASK;
      else               m_lfsr <= m_lfsr >> 1;
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; din = 2'd0; dith_en = 1'b0;
      repeat (3) @(negedge clk);
      mv = 0; ssum = 0;
      rst_n = 1'b1;
   endtask

   task automatic step(input logic [1:0] d, input logic de, input string tag);
      exp_t e;
      int   s;
      @(negedge clk);
      din = d; dith_en = de;
      if (!d[0])      s = 0;
      else if (mv > 0) s = 1;
      else if (mv < 0) s = -1;
      else if (de)     s = m_lfsr[0] ? 1 : -1;
      else             s = 1;
      mv = mv - s;
      e.a = ((int'(d) + s) / 2) != 0;
      e.b = ((int'(d) - s) / 2) != 0;
      e.d = d;
      e.tag = tag;
      q_exp.push_back(e);
   endtask

   // monitor
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         #(PER/4);
         if (q_exp.size() != 0) begin
            e = q_exp.pop_front();
            n_checks++;
            if (out_a !== e.a || out_b !== e.b) begin
               n_fail++;
               $display("FAIL %s din=%0d actual a=%0b b=%0b expected a=%0b b=%0b",
                        e.tag, e.d, out_a, out_b, e.a, e.b);
            end
            n_checks++;
            if (int'(out_a) + int'(out_b) != int'(e.d)) begin
               n_fail++;
               $display("FAIL R2 actual sum=%0d expected %0d",
                        int'(out_a) + int'(out_b), e.d);
            end
            if (e.d[0]) begin
               ssum = ssum + int'(out_a) - int'(out_b);
               n_checks++;
               if (ssum > 1 || ssum < -1) begin
                  n_fail++;
                  $display("FAIL R8 actual running sum=%0d expected within -1..1", ssum);
               end
            end
         end
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   initial begin
      #(PER * 200000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog actual still running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state: zero sample splits to zero
      step(2'd0, 1'b0, "R1");
      // R5: zero state default +1, alternation from reset
      for (int i = 0; i < 8; i++) step(2'd1, 1'b0, "R5");
      // R1/R4: even samples in between leave the state alone
      step(2'd1, 1'b0, "R4");
      step(2'd2, 1'b0, "R1");
      step(2'd0, 1'b0, "R1");
      step(2'd1, 1'b0, "R3");
      step(2'd2, 1'b0, "R1");
      step(2'd1, 1'b0, "R4");
      // R6/R7: dithered run, even samples slide the random phase
      for (int i = 0; i < 300; i++) begin
         logic [1:0] d;
         d = (i % 5 == 2) ? 2'd2 : ((i % 7 == 3) ? 2'd0 : 2'd1);
         step(d, 1'b1, "R6");
      end
      // R7: LFSR keeps running through a long even stretch
      for (int i = 0; i < 37; i++) step(2'd0, 1'b1, "R7");
      for (int i = 0; i < 40; i++) step(2'd1, 1'b1, "R7");
      // dither toggled between samples
      for (int i = 0; i < 60; i++) step(2'd1, (i % 3) != 0, "R3");
      // R4: reset in mid-run restarts integrator and random source
      step(2'd1, 1'b0, "R4");
      do_reset();
      step(2'd1, 1'b0, "R4");
      step(2'd1, 1'b0, "R5");
      for (int i = 0; i < 50; i++) step(2'(i % 3), 1'b1, "R6");
      @(negedge clk);
      din = 2'd0;
      repeat (3) @(negedge clk);
      finished = 1;
      summary();
      $finish;
   end
endmodule